// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous NRZ serial frames on a single output line, one bit per period of an external bit-rate tick. A mode input picks either a 10-bit frame or an 11-bit frame. The 10-bit frame is a start bit, eight data bits and a stop bit. The 11-bit frame adds a ninth bit between the data and the stop bit. That ninth bit is either a parity bit computed over the byte or a control value that travels with the byte.

Besides data frames, the block can emit two special frames on request. The first is a whole frame of ones with no start bit. The second is a whole frame of zeros with no stop bit. Both follow the frame length currently selected. After the frame of zeros, the block always drives one bit-time of ones as a guard, so a receiver can find the next start edge.

Bytes enter through a valid/ready handshake into a single holding register. Generating the bit-rate tick is left to the surrounding logic.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset, and at all times while no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: With `wide_mode`=0, a data frame is 10 bits sent in this order: a 0 start bit, the eight bits of `byte_in` least significant bit first (bit 0 right after the start bit), and a 1 stop bit.
- R3: With `wide_mode`=1, a data frame is 11 bits sent in this order: a 0 start bit, eight data bits least significant bit first, a ninth bit, and a 1 stop bit.
- R4: In an 11-bit frame with `par_en`=1, the ninth bit is parity over the byte. With `par_odd`=0 the count of ones in the byte plus the ninth bit is even. With `par_odd`=1 that count is odd.
- R5: In an 11-bit frame with `par_en`=0, the ninth bit equals `ctl_bit` as it was when the byte was taken.
- R6: `byte_ready` is 1 only when no frame is pending or in progress and neither `brk_req` nor `idle_req` is high. A byte is taken on a clock edge where `byte_valid` and `byte_ready` are both 1. Byte, mode and parity inputs that change while a frame is pending or in progress have no effect on that frame.
- R7: A high `idle_req` between frames produces an idle frame: 10 or 11 bit-times (per `wide_mode`) of 1 with `busy` high, and no start bit.
- R8: A high `brk_req` between frames produces a break frame: 10 or 11 bit-times of 0, followed by exactly one bit-time of 1 (still `busy`) before any later frame can start.
- R9: `brk_req` and `idle_req` are acted on only between frames. A pulse on either during a frame has no effect. When several are present at once, break wins over idle, and idle wins over a byte.
- R10: Each bit is held for exactly one `bit_tick` period. The first bit starts on the first `bit_tick` after the frame is taken. `txd` changes only on a clock edge where `bit_tick` is 1.
- R11: `busy` rises on the tick that starts the first bit of a frame. It stays 1 until the tick that ends the last bit (the stop bit, the last idle bit, or the break guard bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| byte_in | input | 8 | Byte to send |
| byte_valid | input | 1 | `byte_in` is offered |
| byte_ready | output | 1 | A byte can be taken this cycle |
| ctl_bit | input | 1 | Ninth-bit value when parity is off |
| wide_mode | input | 1 | 0: 10-bit frames, 1: 11-bit frames |
| par_en | input | 1 | 1: ninth bit is parity |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| idle_req | input | 1 | Request an all-ones frame |
| brk_req | input | 1 | Request an all-zeros frame plus guard |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame bit is on the line |

## Verification
Data frames are sent with bytes that have alternating, clustered and single-bit patterns. This separates correct bit order from reversed or shifted order. Both parity senses are tried on bytes with even and with odd counts of ones, and both control values are sent with parity off. This catches a swapped parity sense or a parity/control mix-up. Idle and break frames are sent in both frame sizes, with the break guard bit checked for value and length. Requests, mode changes and new bytes are injected in the middle of a frame, and all three requests are raised together. These patterns show whether the rest-only and priority rules hold.

// File: rtl/ser_frame_pkg.sv
// Package: shared types for the serial frame transmitter.
// Assumes: nothing beyond standard SystemVerilog.
package ser_frame_pkg;

    // Kind of frame loaded into the shifter
    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_IDLE  = 2'd1,
        FK_BREAK = 2'd2
    } frame_kind_e;

endpackage

// File: rtl/ser_parity_gen.sv
// Module: parity bit over one data word.
// Produces the bit that makes the total count of ones even (odd_sel=0)
// or odd (odd_sel=1). Purely combinational.
module ser_parity_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd_sel,
    output logic              par_bit
);

    // Reduction XOR gives even parity; invert for odd
    always_comb begin
        par_bit = (^data) ^ odd_sel;
    end

endmodule

// File: rtl/ser_frame_builder.sv
// Module: builds the full bit pattern and bit count of one frame.
// Bit 0 of the pattern goes out first; unused upper bits are 1.
// Assumes the caller samples the outputs only on the cycle a frame is taken.
module ser_frame_builder
    import ser_frame_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRM_MAX = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRM_MAX + 1)
) (
    input  frame_kind_e        kind,
    input  logic               wide,
    input  logic [DATA_W-1:0]  data,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               ctl,
    output logic [FRM_MAX-1:0] pattern,
    output logic [CNT_W-1:0]   length
);

    localparam int NARROW_LEN = DATA_W + 2;
    localparam int WIDE_LEN   = DATA_W + 3;
    localparam int NINTH_POS  = DATA_W + 1;

    logic             par_bit;
    logic             ninth;
    logic [CNT_W-1:0] base_len;

    ser_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data    (data),
        .odd_sel (par_odd),
        .par_bit (par_bit)
    );

    // Pick the ninth bit source and the frame length for the selected size
    always_comb begin
        ninth    = par_en ? par_bit : ctl;
        base_len = wide ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN);
    end

    // Assemble the pattern for the requested frame kind
    always_comb begin
        pattern = '1;
        length  = base_len;
        case (kind)
            FK_DATA: begin
                pattern[0]        = 1'b0;
                pattern[DATA_W:1] = data;
                if (wide) begin
                    pattern[NINTH_POS] = ninth;
                end
            end
            FK_IDLE: begin
                pattern = '1;
            end
            FK_BREAK: begin
                for (int i = 0; i < FRM_MAX; i++) begin
                    pattern[i] = (CNT_W'(i) >= base_len);
                end
                length = base_len + CNT_W'(1);
            end
            default: begin
                pattern = '1;
            end
        endcase
    end

endmodule

// File: rtl/ser_bit_shifter.sv
// Module: paces a loaded pattern onto the line, one bit per tick.
// After a load it waits for the next tick, then sends `len` bits LSB first,
// each for one tick period, and returns the line to 1.
// Assumes `load` is raised only while neither armed nor busy.
module ser_bit_shifter #(
    parameter int FRM_MAX = 12,
    parameter int CNT_W   = $clog2(FRM_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               load,
    input  logic [FRM_MAX-1:0] pat,
    input  logic [CNT_W-1:0]   len,
    output logic               line,
    output logic               active,
    output logic               armed
);

    logic [FRM_MAX-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;
    logic               armed_q;
    logic               active_q;
    logic               line_q;

    // Load, start on the next tick, then shift one bit per tick until empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '1;
            left_q   <= '0;
            armed_q  <= 1'b0;
            active_q <= 1'b0;
            line_q   <= 1'b1;
        end else if (load) begin
            sh_q    <= pat;
            left_q  <= len;
            armed_q <= 1'b1;
        end else if (bit_tick && armed_q) begin
            armed_q  <= 1'b0;
            active_q <= 1'b1;
            line_q   <= sh_q[0];
            sh_q     <= {1'b1, sh_q[FRM_MAX-1:1]};
            left_q   <= left_q - CNT_W'(1);
        end else if (bit_tick && active_q) begin
            if (left_q == '0) begin
                active_q <= 1'b0;
                line_q   <= 1'b1;
            end else begin
                line_q <= sh_q[0];
                sh_q   <= {1'b1, sh_q[FRM_MAX-1:1]};
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // Drive the outputs from the registers
    always_comb begin
        line   = line_q;
        active = active_q;
        armed  = armed_q;
    end

endmodule

// File: rtl/ser_frame_tx.sv
// Module: top of the serial frame transmitter.
// Arbitrates between break, idle and byte requests while at rest, builds the
// frame and hands it to the shifter. Requests during a frame are not stored.
// Assumes bit_tick is a one-cycle pulse and the line is 1 at rest.
module ser_frame_tx
    import ser_frame_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic              ctl_bit,
    input  logic              wide_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              idle_req,
    input  logic              brk_req,
    output logic              txd,
    output logic              busy
);

    localparam int FRM_MAX = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRM_MAX + 1);

    logic               rest;
    logic               armed;
    logic               active;
    logic               load;
    frame_kind_e        sel_kind;
    logic [FRM_MAX-1:0] pattern;
    logic [CNT_W-1:0]   length;

    // Arbitration at rest: break first, then idle, then a byte
    always_comb begin
        rest       = !armed && !active;
        byte_ready = rest && !brk_req && !idle_req;
        if (brk_req) begin
            sel_kind = FK_BREAK;
        end else if (idle_req) begin
            sel_kind = FK_IDLE;
        end else begin
            sel_kind = FK_DATA;
        end
        load = rest && (brk_req || idle_req || byte_valid);
    end

    ser_frame_builder #(
        .DATA_W  (DATA_W),
        .FRM_MAX (FRM_MAX),
        .CNT_W   (CNT_W)
    ) u_build (
        .kind    (sel_kind),
        .wide    (wide_mode),
        .data    (byte_in),
        .par_en  (par_en),
        .par_odd (par_odd),
        .ctl     (ctl_bit),
        .pattern (pattern),
        .length  (length)
    );

    ser_bit_shifter #(
        .FRM_MAX (FRM_MAX),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load     (load),
        .pat      (pattern),
        .len      (length),
        .line     (txd),
        .active   (active),
        .armed    (armed)
    );

    // Busy follows the shifter's active flag
    always_comb begin
        busy = active;
    end

endmodule

// File: rtl/ser_frame_tx_chk.sv
// Module: assertion checker for ser_frame_tx, bound into every instance.
// Tracks the kind of the last taken frame from the ports and the rest flag.
module ser_frame_tx_chk
    import ser_frame_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic byte_valid,
    input logic byte_ready,
    input logic idle_req,
    input logic brk_req,
    input logic rest,
    input logic txd,
    input logic busy
);

    frame_kind_e kind_q;

    // Remember which kind of frame was taken most recently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= FK_DATA;
        end else if (rest && brk_req) begin
            kind_q <= FK_BREAK;
        end else if (rest && idle_req) begin
            kind_q <= FK_IDLE;
        end else if (byte_valid && byte_ready) begin
            kind_q <= FK_DATA;
        end
    end

    AST_LINE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (!busy && !brk_req && !idle_req)); // R6
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !byte_ready); // R6
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd)); // R10
    AST_BUSY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bit_tick)); // R11
    AST_DATA_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && kind_q == FK_DATA) |-> !txd); // R2
    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && kind_q == FK_IDLE) |-> txd); // R7
    AST_BREAK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && kind_q == FK_BREAK) |-> $past(txd)); // R8

endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .idle_req   (idle_req),
    .brk_req    (brk_req),
    .rest       (rest),
    .txd        (txd),
    .busy       (busy)
);

// File: tb/ser_frame_tx_bench.sv
`timescale 1ns/1ps
module ser_frame_tx_bench;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic       ctl_bit = 1'b0;
    logic       wide_mode = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       idle_req = 1'b0;
    logic       brk_req = 1'b0;
    logic       txd;
    logic       busy;

    int n_checks = 0;
    int n_fail = 0;
    int div_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser_frame_tx u_ser_frame_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .ctl_bit    (ctl_bit),
        .wide_mode  (wide_mode),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .idle_req   (idle_req),
        .brk_req    (brk_req),
        .txd        (txd),
        .busy       (busy)
    );

    // Tick generator: one-cycle pulse every DIV cycles, driven at negedge
    always @(negedge clk) begin
        if (!rst_n) begin
            div_cnt  <= 0;
            bit_tick <= 1'b0;
        end else begin
            div_cnt  <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
            bit_tick <= (div_cnt == DIV - 1);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected frame from the requirements; kind 0 data, 1 idle, 2 break
    task automatic expect_frame(input int kind, input bit wide, input logic [7:0] d,
                                input bit pe, input bit po, input bit ctl,
                                output logic [15:0] bits, output int n);
        int len;
        len  = wide ? 11 : 10;
        bits = '1;
        n    = len;
        if (kind == 0) begin
            bits[0] = 1'b0;
            for (int i = 0; i < 8; i++) bits[i+1] = d[i];
            if (wide) bits[9] = pe ? ((^d) ^ po) : ctl;
        end else if (kind == 2) begin
            for (int i = 0; i < len; i++) bits[i] = 1'b0;
            n = len + 1;
        end
    endtask

    // Capture n bits starting at busy rise; checks each is held DIV cycles
    task automatic grab(input int n, output logic [15:0] bits, output bit steady);
        steady = 1'b1;
        bits   = '1;
        while (!busy) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            bits[b] = txd;
            for (int c = 0; c < DIV; c++) begin
                if (txd !== bits[b] || busy !== 1'b1) steady = 1'b0;
                @(negedge clk);
            end
        end
    endtask

    task automatic offer_byte(input logic [7:0] d);
        while (!byte_ready) @(negedge clk);
        byte_in    = d;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic after_frame(input string tag);
        check(txd === 1'b1 && busy === 1'b0, tag, {14'd0, txd, busy}, 16'h0002);
    endtask

    task automatic quiet_for(input int cycles, input string tag);
        bit ok;
        ok = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (txd !== 1'b1 || busy !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, tag, {15'd0, ok}, 16'h0001);
    endtask

    task automatic t_reset();
        check(txd === 1'b1 && busy === 1'b0, "R1 reset line", {14'd0, txd, busy}, 16'h0002);
        check(byte_ready === 1'b1, "R6 ready after reset", {15'd0, byte_ready}, 16'h0001);
    endtask

    task automatic t_data(input logic [7:0] d, input bit wide, input bit pe,
                          input bit po, input bit ctl, input string tag);
        logic [15:0] exp, got;
        int n;
        bit steady;
        wide_mode = wide; par_en = pe; par_odd = po; ctl_bit = ctl;
        expect_frame(0, wide, d, pe, po, ctl, exp, n);
        offer_byte(d);
        grab(n, got, steady);
        check(got === exp, tag, got, exp);
        check(steady, "R10 R11 bit hold and busy", {15'd0, steady}, 16'h0001);
        after_frame("R1 line back at rest");
    endtask

    task automatic t_special(input int kind, input bit wide, input string tag);
        logic [15:0] exp, got;
        int n;
        bit steady;
        wide_mode = wide;
        expect_frame(kind, wide, 8'h00, 1'b0, 1'b0, 1'b0, exp, n);
        while (!byte_ready) @(negedge clk);
        if (kind == 2) brk_req = 1'b1; else idle_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0; idle_req = 1'b0;
        grab(n, got, steady);
        check(got === exp, tag, got, exp);
        check(steady, "R11 busy through special frame", {15'd0, steady}, 16'h0001);
        after_frame("R1 rest after special frame");
    endtask

    // Requests, bytes and mode changes in mid-frame must not alter anything
    task automatic t_ignore_busy();
        logic [15:0] exp, got;
        int n;
        bit steady;
        wide_mode = 1'b0; par_en = 1'b0;
        expect_frame(0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0, exp, n);
        offer_byte(8'h96);
        fork
            grab(n, got, steady);
            begin
                while (!busy) @(negedge clk);
                repeat (2 * DIV) @(negedge clk);
                check(byte_ready === 1'b0, "R6 ready low during frame", {15'd0, byte_ready}, 16'h0000);
                byte_in = 8'h00; byte_valid = 1'b1; brk_req = 1'b1; idle_req = 1'b1;
                wide_mode = 1'b1; par_en = 1'b1; byte_in = 8'hFF;
                @(negedge clk);
                byte_valid = 1'b0; brk_req = 1'b0; idle_req = 1'b0;
            end
        join
        wide_mode = 1'b0; par_en = 1'b0;
        check(got === exp, "R6 R9 frame unchanged by mid-frame inputs", got, exp);
        quiet_for(4 * DIV, "R9 no frame from mid-frame requests");
    endtask

    // All requests at once: break first, then idle over a byte
    task automatic t_priority();
        logic [15:0] exp, got;
        int n;
        bit steady;
        wide_mode = 1'b0;
        while (!byte_ready) @(negedge clk);
        byte_in = 8'h55; byte_valid = 1'b1; brk_req = 1'b1; idle_req = 1'b1;
        #0;
        check(byte_ready === 1'b0, "R6 ready masked by requests", {15'd0, byte_ready}, 16'h0000);
        @(negedge clk);
        byte_valid = 1'b0; brk_req = 1'b0; idle_req = 1'b0;
        expect_frame(2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, exp, n);
        grab(n, got, steady);
        check(got === exp, "R9 break wins", got, exp);
        quiet_for(3 * DIV, "R9 byte not taken alongside break");
        while (!byte_ready) @(negedge clk);
        byte_in = 8'h00; byte_valid = 1'b1; idle_req = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; idle_req = 1'b0;
        expect_frame(1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, exp, n);
        grab(n, got, steady);
        check(got === exp, "R9 idle wins over byte", got, exp);
        quiet_for(3 * DIV, "R9 byte not taken alongside idle");
    endtask

    // Break then byte: guard bit of 1 must precede the start bit
    task automatic t_break_then_data();
        logic [15:0] exp, got;
        int n;
        bit steady;
        wide_mode = 1'b1;
        while (!byte_ready) @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        fork
            begin
                expect_frame(2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, exp, n);
                grab(n, got, steady);
                check(got[11:10] === 2'b10 && steady, "R8 guard bit one period", got, exp);
            end
            begin
                byte_in = 8'h81; byte_valid = 1'b1;
                while (!byte_ready) @(negedge clk);
                @(negedge clk);
                byte_valid = 1'b0;
            end
        join
        par_en = 1'b1; par_odd = 1'b0;
        expect_frame(0, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0, exp, n);
        grab(n, got, steady);
        check(got[0] === 1'b0 && got[8:1] === 8'h81, "R8 data after guard", got, exp);
        after_frame("R1 rest after break and data");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R2 narrow frame A5");
        t_data(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R2 narrow frame 01");
        t_data(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R4 wide even parity 3C");
        t_data(8'h07, 1'b1, 1'b1, 1'b0, 1'b0, "R4 even parity odd count");
        t_data(8'h07, 1'b1, 1'b1, 1'b1, 1'b0, "R4 odd parity 07");
        t_data(8'hF0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 odd parity F0");
        t_data(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, "R5 control bit one");
        t_data(8'h5B, 1'b1, 1'b0, 1'b1, 1'b0, "R5 control bit zero");
        t_special(1, 1'b0, "R7 idle narrow");
        t_special(1, 1'b1, "R7 idle wide");
        t_special(2, 1'b0, "R8 break narrow");
        t_special(2, 1'b1, "R8 break wide");
        t_ignore_busy();
        t_priority();
        t_break_then_data();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule